// File: doc/BRIEF.md
# Over-Current Pulse-Skip Fault Sequencer

This block decides, for a single switching regulator, whether the high-side drive may fire in each switching cycle. It looks at a current-limit flag once per cycle, when the one-clock cycle-start strobe arrives. A limit hit starts a pulse-skip interval in which the high-side drive is held off. After that interval an observation window opens. A second hit inside the window latches the regulator off and drops power-good. An under-voltage flag shuts the regulator down at once and latches the same fault. If the window closes clean, the sequencer returns to normal operation by itself.

A latched fault is cleared only by reset, or by taking the enable input low and then high again. While enable is low, the sequencer is held in its idle state and every output is low. Both asynchronous flags pass through a two-flop synchronizer before any logic uses them.

The controller has four states, reported on `status_o`:

| State | Code | Meaning |
|---|---|---|
| RUN | 0 | Normal operation |
| SKIP | 1 | Pulse-skip interval |
| WATCH | 2 | Observation window |
| TRIP | 3 | Latched fault |

Its transitions are:

- **detect**: RUN to SKIP, on a strobe that samples the limit flag high.
- **arm**: SKIP to WATCH, on the strobe that starts cycle 9 with the flag low.
- **early_trip**: SKIP to TRIP, on the strobe that starts cycle 9 with the flag high.
- **repeat_trip**: WATCH to TRIP, on a strobe with the flag high.
- **release**: WATCH to RUN, when the cycle-16 strobe samples the flag low.
- **uv_trip**: any enabled state to TRIP, on under-voltage.
- **disable**: any state to RUN, while enable is low.

Top module: `oc_fault_seq`

## Requirements
- R1: After reset, and on the clock after enable is seen low, `status_o` is 0 and `hs_gate_o`, `reg_en_o` and `pgood_o` are all low. They stay that way while enable stays low.
- R2: The limit flag is acted on only on a clock where `cyc_start_i` is high. A limit level that rises and falls between strobes leaves `status_o` at 0.
- R3: A strobe in RUN that samples the limit flag high moves to SKIP (`status_o`=1). This is cycle 0. `hs_gate_o` stays low through cycle 0 and the eight cycles after it, and `status_o` stays 1 through them.
- R4: If the strobe that starts cycle 9 samples the flag low, the state becomes WATCH (`status_o`=2) and `hs_gate_o` goes high.
- R5: A strobe that samples the flag high at the start of any cycle from 9 through 16 sets TRIP (`status_o`=3). `reg_en_o`, `pgood_o` and `hs_gate_o` then go low. This includes a hit exactly on cycle 9 and a hit exactly on cycle 16.
- R6: If the strobes for cycles 9 through 16 all sample the flag low, the state returns to RUN (`status_o`=0) on the cycle-16 strobe. A later hit starts a fresh skip sequence.
- R7: TRIP persists whatever the limit flag, the under-voltage flag or the strobe do, as long as enable stays high. It is cleared by enable going low and then high.
- R8: Two clocks after `uv_i` rises, `reg_en_o`, `pgood_o` and `hs_gate_o` are low, with no strobe required. One clock later `status_o` is 3, and it stays latched after `uv_i` falls.
- R9: `ilim_i` and `uv_i` each pass through a two-flop synchronizer. A strobe one clock after `ilim_i` rises does not see the hit. A strobe three clocks after it rises does see the hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| en_i | input | 1 | Regulator enable; a low-then-high pulse clears a latched fault |
| cyc_start_i | input | 1 | One-clock pulse marking the start of a switching cycle |
| ilim_i | input | 1 | Current-limit flag (asynchronous) |
| uv_i | input | 1 | Under-voltage flag (asynchronous) |
| hs_gate_o | output | 1 | High-side drive permitted this cycle |
| reg_en_o | output | 1 | Regulator enable |
| pgood_o | output | 1 | Power-good |
| status_o | output | 2 | State: 0 RUN, 1 SKIP, 2 WATCH, 3 TRIP |

## Verification
The embedded assertions check on every clock that:

- the state moves only on a strobe or on an under-voltage or enable event;
- SKIP never lets the high-side drive through;
- TRIP is sticky while enable is high;
- a disabled block is idle;
- a sampled hit in the watch window trips;
- the cycle counter never passes the end of the window.

Only the bench scenarios can show cycle-exact window edges: a hit on cycle 9 versus cycle 16, a clean cycle 16 returning to RUN, and the synchronizer's latency relative to the strobe. Under-voltage timing and fault clearing through an enable pulse also rely on the bench.

// File: rtl/oc_seq_pkg.sv
package oc_seq_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SKIP  = 2'd1,
        ST_WATCH = 2'd2,
        ST_TRIP  = 2'd3
    } oc_state_e;

endpackage

// File: rtl/oc_sync.sv
module oc_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '0;
            end else begin
                chain <= {chain[STAGES-2:0], d_i[b]};
            end
        end

        assign q_o[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/oc_cyc_cnt.sv
module oc_cyc_cnt #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (clr_i) begin
            cnt_o <= '0;
        end else if (inc_i) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

endmodule

// File: rtl/oc_seq_fsm.sv
module oc_seq_fsm
    import oc_seq_pkg::*;
#(
    parameter int SKIP_CYC  = 8,
    parameter int WATCH_CYC = 8,
    parameter int CNT_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             strobe_i,
    input  logic             hit_i,
    input  logic             uv_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             clr_o,
    output logic             inc_o,
    output oc_state_e        state_o,
    output logic             hs_gate_o,
    output logic             reg_en_o,
    output logic             pgood_o
);

    localparam logic [CNT_W-1:0] LAST_SKIP = CNT_W'(SKIP_CYC);
    localparam logic [CNT_W-1:0] LAST_WIN  = CNT_W'(SKIP_CYC + WATCH_CYC - 1);
    localparam logic [CNT_W-1:0] CNT_MAX   = CNT_W'(SKIP_CYC + WATCH_CYC);

    oc_state_e state_q, state_d;
    logic      clr_fsm;

    // Next-state and counter control.
    always_comb begin
        state_d = state_q;
        clr_fsm = 1'b0;
        inc_o   = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (strobe_i && hit_i) begin
                    state_d = ST_SKIP;
                    clr_fsm = 1'b1;
                end
            end
            ST_SKIP: begin
                if (strobe_i) begin
                    inc_o = 1'b1;
                    if (cnt_i == LAST_SKIP) begin
                        state_d = hit_i ? ST_TRIP : ST_WATCH;
                    end
                end
            end
            ST_WATCH: begin
                if (strobe_i) begin
                    if (hit_i) begin
                        state_d = ST_TRIP;
                    end else if (cnt_i == LAST_WIN) begin
                        state_d = ST_RUN;
                        clr_fsm = 1'b1;
                    end else begin
                        inc_o = 1'b1;
                    end
                end
            end
            ST_TRIP: begin
                state_d = ST_TRIP;
            end
            default: state_d = ST_RUN;
        endcase
        if (uv_i) begin
            state_d = ST_TRIP;
        end
    end

    assign clr_o = clr_fsm || !en_i;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else if (!en_i) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs.
    always_comb begin
        reg_en_o  = en_i && !uv_i && (state_q != ST_TRIP);
        pgood_o   = reg_en_o;
        hs_gate_o = reg_en_o && ((state_q == ST_RUN) || (state_q == ST_WATCH));
    end

    assign state_o = state_q;

    // R2
    strobe_only_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !strobe_i && !uv_i) |=> $stable(state_q));

    // R3
    skip_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SKIP) |-> !hs_gate_o);

    // R5
    window_hit_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && state_q == ST_WATCH && strobe_i && hit_i) |=> (state_q == ST_TRIP || !$past(en_i)));

    // R7
    trip_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRIP && en_i) |=> (state_q == ST_TRIP || !en_i));

    // R1
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (state_q == ST_RUN && (!en_i || $rose(en_i))));

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_i <= CNT_MAX);

endmodule

// File: rtl/oc_fault_seq.sv
module oc_fault_seq
    import oc_seq_pkg::*;
#(
    parameter int SKIP_CYC    = 8,
    parameter int WATCH_CYC   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       cyc_start_i,
    input  logic       ilim_i,
    input  logic       uv_i,
    output logic       hs_gate_o,
    output logic       reg_en_o,
    output logic       pgood_o,
    output logic [1:0] status_o
);

    localparam int CNT_W = $clog2(SKIP_CYC + WATCH_CYC + 1);

    logic [1:0]       sync_q;
    logic             clr, inc;
    logic [CNT_W-1:0] cnt;
    oc_state_e        state;

    oc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({uv_i, ilim_i}),
        .q_o   (sync_q)
    );

    oc_cyc_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr),
        .inc_i (inc),
        .cnt_o (cnt)
    );

    oc_seq_fsm #(
        .SKIP_CYC  (SKIP_CYC),
        .WATCH_CYC (WATCH_CYC),
        .CNT_W     (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_i),
        .strobe_i  (cyc_start_i),
        .hit_i     (sync_q[0]),
        .uv_i      (sync_q[1]),
        .cnt_i     (cnt),
        .clr_o     (clr),
        .inc_o     (inc),
        .state_o   (state),
        .hs_gate_o (hs_gate_o),
        .reg_en_o  (reg_en_o),
        .pgood_o   (pgood_o)
    );

    assign status_o = state;

endmodule

// File: tb/test_oc_fault_seq.sv
`timescale 1ns/1ps
module test_oc_fault_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_i = 1'b0;
    logic       cyc_start_i = 1'b0;
    logic       ilim_i = 1'b0;
    logic       uv_i = 1'b0;
    logic       hs_gate_o, reg_en_o, pgood_o;
    logic [1:0] status_o;

    int errors = 0;
    int checks = 0;
    int mst = 0;
    int mcnt = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    oc_fault_seq i_oc_fault_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en_i),
        .cyc_start_i (cyc_start_i),
        .ilim_i      (ilim_i),
        .uv_i        (uv_i),
        .hs_gate_o   (hs_gate_o),
        .reg_en_o    (reg_en_o),
        .pgood_o     (pgood_o),
        .status_o    (status_o)
    );

    function automatic bit exp_en();
        return en_i && (mst != 3);
    endfunction

    function automatic bit exp_gate();
        return exp_en() && (mst == 0 || mst == 2);
    endfunction

    task automatic check_val(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req);
        check_val(req, int'(status_o), mst, "status");
        check_val(req, int'(hs_gate_o), int'(exp_gate()), "hs_gate");
        check_val(req, int'(reg_en_o), int'(exp_en()), "reg_en");
        check_val(req, int'(pgood_o), int'(exp_en()), "pgood");
    endtask

    task automatic model_step(bit hit);
        if (mst == 0) begin
            if (hit) begin mst = 1; mcnt = 0; end
        end else if (mst == 1) begin
            if (mcnt == 8) mst = hit ? 3 : 2;
            mcnt++;
        end else if (mst == 2) begin
            if (hit) mst = 3;
            else if (mcnt == 15) begin mst = 0; mcnt = 0; end
            else mcnt++;
        end
    endtask

    // One switching cycle: limit level settles, then a one-clock strobe.
    task automatic do_cycle(bit hit, string req);
        @(negedge clk) ilim_i = hit;
        repeat (3) @(negedge clk);
        cyc_start_i = 1'b1;
        @(negedge clk) cyc_start_i = 1'b0;
        model_step(hit);
        check_all(req);
    endtask

    task automatic do_uv(string req);
        @(negedge clk) uv_i = 1'b1;
        repeat (2) @(negedge clk);
        check_val(req, int'(reg_en_o), 0, "reg_en after uv");
        check_val(req, int'(hs_gate_o), 0, "hs_gate after uv");
        check_val(req, int'(pgood_o), 0, "pgood after uv");
        @(negedge clk);
        mst = 3;
        check_all(req);
        uv_i = 1'b0;
        repeat (3) @(negedge clk);
        check_all(req);
    endtask

    task automatic toggle_en(string req);
        @(negedge clk) en_i = 1'b0;
        @(negedge clk);
        mst = 0; mcnt = 0;
        check_all(req);
        en_i = 1'b1;
        @(negedge clk);
        check_all(req);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd2024);

        // R1 reset state
        repeat (3) @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");
        en_i = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R2 limit level between strobes is ignored
        @(negedge clk) ilim_i = 1'b1;
        repeat (5) @(negedge clk);
        ilim_i = 1'b0;
        repeat (3) @(negedge clk);
        check_all("R2");
        do_cycle(1'b0, "R2");

        // R9 strobe one clock after rise misses the hit
        @(negedge clk) ilim_i = 1'b1;
        @(negedge clk) cyc_start_i = 1'b1;
        @(negedge clk) begin cyc_start_i = 1'b0; ilim_i = 1'b0; end
        check_all("R9");
        repeat (3) @(negedge clk);

        // R3/R5 hit exactly on cycle 9
        do_cycle(1'b1, "R3");
        for (int i = 0; i < 8; i++) do_cycle(1'b0, "R3");
        do_cycle(1'b1, "R5");
        do_cycle(1'b0, "R7");
        do_cycle(1'b1, "R7");
        toggle_en("R7");

        // R4/R5 hit exactly on cycle 16
        do_cycle(1'b1, "R9");
        for (int i = 0; i < 8; i++) do_cycle(1'b0, "R3");
        do_cycle(1'b0, "R4");
        for (int i = 0; i < 6; i++) do_cycle(1'b0, "R4");
        do_cycle(1'b1, "R5");
        toggle_en("R7");

        // R6 clean window returns to normal, then a fresh detection
        do_cycle(1'b1, "R3");
        for (int i = 0; i < 15; i++) do_cycle(1'b0, "R6");
        do_cycle(1'b0, "R6");
        do_cycle(1'b1, "R6");
        for (int i = 0; i < 8; i++) do_cycle(1'b0, "R6");

        // R8 under-voltage mid-window
        do_uv("R8");
        toggle_en("R8");

        // Random mix
        for (int i = 0; i < 600; i++) begin
            int r;
            r = int'($urandom % 100);
            if (r < 2) do_uv("R8");
            else if (r < 6 || (mst == 3 && r < 30)) toggle_en("R7");
            else do_cycle(($urandom % 5) == 0, "R5");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule